// File: doc/BRIEF.md
# Stack Evaluation Unit with Flags

This block is a small zero-address computing stack. Each accepted instruction carries a 3-bit opcode and, for a push, a data word. Arithmetic and logic operations take their operands only from the top of the internal stack and write their result back to the stack, so no instruction carries an operand address. Values leave the block only through a pop, which presents the removed word on the result port together with a one-cycle valid pulse.

Status outputs show whether the stack is full or empty. An instruction that would overrun or underrun the stack is dropped. It leaves the stack exactly as it was and sets a sticky error flag instead. There are two such flags, one for overflow and one for an empty or too-shallow stack. Both stay set until the clear input is pulsed. Storage is a bank of registers inside the block. Instruction fetch and sequencing belong to the surrounding logic.

Top module: `stack_calc_unit`

## Requirements
- R1: After reset the stack holds no entries: `isEmpty` is 1, `isFull` is 0, both error flags are 0 and `dataOutValid` is 0.
- R2: PUSH (opcode 001) with `instrValid` high captures `dataIn` on the accepting clock edge as the new top. The depth counts entries from 0 to 8. `isFull` is 1 exactly at depth 8 and `isEmpty` is 1 exactly at depth 0.
- R3: POP (opcode 010) on a non-empty stack removes the top entry and drives it on `dataOut`, with `dataOutValid` high for exactly one cycle after the accepting edge. Entries come back last-in first-out.
- R4: A PUSH while `isFull` is 1 writes nothing, so the stored entries remain unchanged, and it sets `overflowErr`.
- R5: A POP while `isEmpty` is 1 produces no valid pulse, leaves the stack unchanged and sets `underflowErr`.
- R6: SHL (opcode 011) replaces the top entry in place with that entry shifted left by one bit, with the MSB dropped and a 0 shifted in. On an empty stack it sets `underflowErr` and changes nothing.
- R7: ADD (opcode 100) removes the top two entries and pushes their sum modulo 2^16, so the depth drops by one.
- R8: SUB (opcode 101) removes the top two entries and pushes the second entry minus the top entry, modulo 2^16.
- R9: AND (opcode 110) removes the top two entries and pushes their bitwise AND.
- R10: SWAP (opcode 111) exchanges the top two entries and keeps the depth.
- R11: ADD, SUB, AND or SWAP issued with fewer than two entries sets `underflowErr` and leaves the stack unchanged.
- R12: The error flags stay set until `clearErr` is high at a clock edge. If an instruction fails in the same cycle as a clear, the flag it raises is set after that edge.
- R13: NOP (opcode 000), and any opcode presented while `instrValid` is low, change neither the stack, the flags nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instrValid | input | 1 | Qualifies the opcode for one instruction per cycle |
| opcode | input | 3 | Instruction code |
| dataIn | input | 16 | Operand for PUSH |
| clearErr | input | 1 | Clears both sticky error flags |
| dataOut | output | 16 | Word removed by the last POP |
| dataOutValid | output | 1 | One-cycle pulse after a successful POP |
| isFull | output | 1 | Stack holds 8 entries |
| isEmpty | output | 1 | Stack holds no entries |
| overflowErr | output | 1 | Sticky: a PUSH hit a full stack |
| underflowErr | output | 1 | Sticky: an operation lacked entries |

## Verification
A failing instruction and an error clear can land on the same clock edge, and these two updates pull the same flag in opposite directions. The bench drives an empty-stack POP together with `clearErr` high, and a clear alone while a flag is set. The expected flag after each edge is taken from the set-wins rule. Random traffic also pulses the clear now and then during faulting instructions. A reference stack model tracks each flag after every instruction, and a scoreboard compares every popped word.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'b000,
    OP_PUSH = 3'b001,
    OP_POP  = 3'b010,
    OP_SHL  = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_AND  = 3'b110,
    OP_SWAP = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2
  } aluSel_e;

  typedef struct packed {
    logic    push;
    logic    pop;
    logic    shl;
    logic    binop;
    logic    swap;
    aluSel_e aluSel;
  } stackStrobe_t;

endpackage

// File: rtl/stack_calc_ctrl.sv
module stack_calc_ctrl
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrValid,
  input  logic [2:0]    opcode,
  input  logic          clearErr,
  input  logic [CW-1:0] count,
  output stackStrobe_t  strobe,
  output logic          overflowErr,
  output logic          underflowErr
);

  logic stackFull, stackEmpty, hasTwo;
  logic ovfHit, unfHit;

  assign stackFull  = (count == CW'(DEPTH));
  assign stackEmpty = (count == '0);
  assign hasTwo     = (count >= CW'(2));

  always_comb begin
    strobe = '0;
    ovfHit = 1'b0;
    unfHit = 1'b0;
    if (instrValid) begin
      case (opcode_e'(opcode))
        OP_PUSH: if (stackFull) ovfHit = 1'b1; else strobe.push = 1'b1;
        OP_POP:  if (stackEmpty) unfHit = 1'b1; else strobe.pop = 1'b1;
        OP_SHL:  if (stackEmpty) unfHit = 1'b1; else strobe.shl = 1'b1;
        OP_ADD: begin
          strobe.aluSel = ALU_ADD;
          if (!hasTwo) unfHit = 1'b1; else strobe.binop = 1'b1;
        end
        OP_SUB: begin
          strobe.aluSel = ALU_SUB;
          if (!hasTwo) unfHit = 1'b1; else strobe.binop = 1'b1;
        end
        OP_AND: begin
          strobe.aluSel = ALU_AND;
          if (!hasTwo) unfHit = 1'b1; else strobe.binop = 1'b1;
        end
        OP_SWAP: if (!hasTwo) unfHit = 1'b1; else strobe.swap = 1'b1;
        default: ;
      endcase
    end
  end

  // Sticky flags: a new fault outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      overflowErr  <= ovfHit | (overflowErr  & ~clearErr);
      underflowErr <= unfHit | (underflowErr & ~clearErr);
    end
  end

  // R4
  push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode == OP_PUSH && count == CW'(DEPTH)) |=> overflowErr);

  // R11
  short_binop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opcode[2] && count < CW'(2)) |=> underflowErr);

  // R12
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !clearErr) |=> overflowErr);

  // R12
  sticky_unf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowErr && !clearErr) |=> underflowErr);

endmodule

// File: rtl/stack_calc_dp.sv
module stack_calc_dp
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStrobe_t     strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [CW-1:0]    count,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutValid
);

  logic [WIDTH-1:0] stk [DEPTH];
  logic [IW-1:0]    topIdx, secIdx, pushIdx;
  logic [WIDTH-1:0] topVal, secVal, aluRes;

  assign topIdx  = IW'(count - CW'(1));
  assign secIdx  = IW'(count - CW'(2));
  assign pushIdx = IW'(count);
  assign topVal  = stk[topIdx];
  assign secVal  = stk[secIdx];

  always_comb begin
    case (strobe.aluSel)
      ALU_ADD: aluRes = secVal + topVal;
      ALU_SUB: aluRes = secVal - topVal;
      ALU_AND: aluRes = secVal & topVal;
      default: aluRes = secVal;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stk[g] <= '0;
      end else if (strobe.push && pushIdx == IW'(g)) begin
        stk[g] <= dataIn;
      end else if (strobe.shl && topIdx == IW'(g)) begin
        stk[g] <= {topVal[WIDTH-2:0], 1'b0};
      end else if (strobe.binop && secIdx == IW'(g)) begin
        stk[g] <= aluRes;
      end else if (strobe.swap && topIdx == IW'(g)) begin
        stk[g] <= secVal;
      end else if (strobe.swap && secIdx == IW'(g)) begin
        stk[g] <= topVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      dataOut      <= '0;
      dataOutValid <= 1'b0;
    end else begin
      dataOutValid <= strobe.pop;
      if (strobe.pop) dataOut <= topVal;
      if (strobe.push)                    count <= count + CW'(1);
      else if (strobe.pop || strobe.binop) count <= count - CW'(1);
    end
  end

  // R2
  push_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> count == $past(count) + CW'(1));

  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> (dataOutValid && dataOut == $past(topVal)));

  // R7
  binop_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.binop |=> count == $past(count) - CW'(1));

  // R10
  swap_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swap |=> $stable(count));

endmodule

// File: rtl/stack_calc_unit.sv
module stack_calc_unit
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [2:0]       opcode,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             clearErr,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutValid,
  output logic             isFull,
  output logic             isEmpty,
  output logic             overflowErr,
  output logic             underflowErr
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  stackStrobe_t  strobe;
  logic [CW-1:0] count;

  stack_calc_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opcode(opcode),
    .clearErr(clearErr), .count(count), .strobe(strobe),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  stack_calc_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .count(count), .dataOut(dataOut), .dataOutValid(dataOutValid)
  );

  assign isFull  = (count == CW'(DEPTH));
  assign isEmpty = (count == '0);

endmodule

// File: tb/stack_calc_unit_bench.sv
module stack_calc_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [2:0]  opcode = 3'b000;
  logic [15:0] dataIn = '0;
  logic        clearErr = 1'b0;
  logic [15:0] dataOut;
  logic        dataOutValid, isFull, isEmpty, overflowErr, underflowErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] mdl[$];
  logic [15:0] scoreQ[$];
  logic expOvf = 1'b0;
  logic expUnf = 1'b0;

  always #2 clk = ~clk;

  stack_calc_unit u_stack_calc_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opcode(opcode),
    .dataIn(dataIn), .clearErr(clearErr), .dataOut(dataOut),
    .dataOutValid(dataOutValid), .isFull(isFull), .isEmpty(isEmpty),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic chkFlags(input string tag);
    chk(tag, "isFull",  {31'd0, isFull},  {31'd0, mdl.size() == 8});
    chk(tag, "isEmpty", {31'd0, isEmpty}, {31'd0, mdl.size() == 0});
    chk(tag, "overflowErr",  {31'd0, overflowErr},  {31'd0, expOvf});
    chk(tag, "underflowErr", {31'd0, underflowErr}, {31'd0, expUnf});
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      3'd7: return "R10";
      default: return "R13";
    endcase
  endfunction

  // Driver: update reference model, queue expected pops, apply one instruction.
  task automatic issue(input logic [2:0] op, input logic [15:0] d,
                       input logic clr, input string tag);
    logic eOvf = 1'b0;
    logic eUnf = 1'b0;
    logic [15:0] t, s;
    case (op)
      3'd1: if (mdl.size() == 8) eOvf = 1'b1; else mdl.push_back(d);
      3'd2: if (mdl.size() == 0) eUnf = 1'b1; else scoreQ.push_back(mdl.pop_back());
      3'd3: if (mdl.size() == 0) eUnf = 1'b1;
            else begin t = mdl.pop_back(); mdl.push_back({t[14:0], 1'b0}); end
      3'd4, 3'd5, 3'd6: if (mdl.size() < 2) eUnf = 1'b1;
            else begin
              t = mdl.pop_back(); s = mdl.pop_back();
              if (op == 3'd4) mdl.push_back(s + t);
              else if (op == 3'd5) mdl.push_back(s - t);
              else mdl.push_back(s & t);
            end
      3'd7: if (mdl.size() < 2) eUnf = 1'b1;
            else begin
              t = mdl.pop_back(); s = mdl.pop_back();
              mdl.push_back(t); mdl.push_back(s);
            end
      default: ;
    endcase
    expOvf = eOvf | (expOvf & ~clr);
    expUnf = eUnf | (expUnf & ~clr);
    instrValid = 1'b1; opcode = op; dataIn = d; clearErr = clr;
    @(negedge clk);
    instrValid = 1'b0; clearErr = 1'b0;
    chkFlags(tag);
  endtask

  task automatic idle(input logic [2:0] op, input logic [15:0] d);
    instrValid = 1'b0; opcode = op; dataIn = d;
    @(negedge clk);
    chkFlags("R13");
    chk("R13", "no pulse when idle", {31'd0, dataOutValid}, 32'd0);
  endtask

  // Monitor: compare every pop pulse against the scoreboard.
  always @(negedge clk) begin
    if (rstN && dataOutValid) begin
      total++;
      if (scoreQ.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected pop act=%h exp=none", dataOut);
      end else begin
        logic [15:0] e;
        e = scoreQ.pop_front();
        if (dataOut !== e) begin
          bad++;
          $display("FAIL R3 pop data act=%h exp=%h", dataOut, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog R1 act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkFlags("R1");
    chk("R1", "dataOutValid", {31'd0, dataOutValid}, 32'd0);

    // R5 pop on empty
    issue(3'd2, 16'h0, 1'b0, "R5");
    chk("R5", "no pulse", {31'd0, dataOutValid}, 32'd0);
    issue(3'd0, 16'h0, 1'b1, "R12");

    // R2 fill, R4 overflow, then R3 drain LIFO
    for (int i = 0; i < 8; i++) issue(3'd1, 16'h1000 + 16'(i * 17), 1'b0, "R2");
    issue(3'd1, 16'hDEAD, 1'b0, "R4");
    issue(3'd1, 16'hBEEF, 1'b0, "R4");
    for (int i = 0; i < 8; i++) issue(3'd2, 16'h0, 1'b0, "R3");
    issue(3'd0, 16'h0, 1'b1, "R12");

    // R6 shift on empty then on a value
    issue(3'd3, 16'h0, 1'b0, "R6");
    issue(3'd1, 16'h8001, 1'b0, "R6");
    issue(3'd3, 16'h0, 1'b0, "R6");
    issue(3'd2, 16'h0, 1'b0, "R6");

    // R7 wrap, R8 order, R9
    issue(3'd1, 16'hFFFF, 1'b0, "R7");
    issue(3'd1, 16'h0003, 1'b0, "R7");
    issue(3'd4, 16'h0, 1'b0, "R7");
    issue(3'd1, 16'h0005, 1'b0, "R8");
    issue(3'd5, 16'h0, 1'b0, "R8");
    issue(3'd1, 16'h0F0F, 1'b0, "R9");
    issue(3'd6, 16'h0, 1'b0, "R9");
    // R10 swap
    issue(3'd1, 16'h1234, 1'b0, "R10");
    issue(3'd7, 16'h0, 1'b0, "R10");
    issue(3'd2, 16'h0, 1'b0, "R10");
    issue(3'd2, 16'h0, 1'b0, "R10");

    // R11 binary ops with fewer than two entries
    issue(3'd4, 16'h0, 1'b0, "R11");
    issue(3'd1, 16'h00AA, 1'b0, "R11");
    issue(3'd5, 16'h0, 1'b0, "R11");
    issue(3'd6, 16'h0, 1'b0, "R11");
    issue(3'd7, 16'h0, 1'b0, "R11");
    issue(3'd2, 16'h0, 1'b0, "R11");

    // R12 clear alone, then fault and clear on the same edge
    issue(3'd0, 16'h0, 1'b1, "R12");
    issue(3'd2, 16'h0, 1'b1, "R12");
    chk("R12", "set wins over clear", {31'd0, underflowErr}, 32'd1);
    idle(3'd0, 16'h0);
    issue(3'd0, 16'h0, 1'b1, "R12");

    // R13 idle and NOP leave state intact
    issue(3'd1, 16'h5A5A, 1'b0, "R13");
    for (int i = 0; i < 8; i++) idle(3'(i), 16'hFFFF);
    issue(3'd0, 16'h7777, 1'b0, "R13");
    issue(3'd2, 16'h0, 1'b0, "R13");

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd2 && $urandom_range(0, 1) == 0) op = 3'd1;
      issue(op, 16'($urandom), ($urandom_range(0, 15) == 0), tagOf(op));
    end

    repeat (2) @(negedge clk);
    chk("R3", "scoreboard drained", scoreQ.size(), 32'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule